// File: doc/BRIEF.md
# Maskable Clear-on-Read Interrupt Collector

This block gathers up to sixteen single-cycle event pulses from neighbouring logic into a sticky status register and drives one level-sensitive interrupt output toward a host. A host-writable enable register decides which recorded events reach that output. Every event is recorded whether it is enabled or not, so a host that keeps all sources disabled can still find out what happened by polling the status register.

The host reaches both registers through a plain one-cycle register port: a select bit picks the status register (0) or the enable register (1), a read strobe returns its contents on the same cycle, and a write strobe loads the enable register. A read of the status register hands back its contents and wipes every recorded bit at the following clock edge. Any event arriving in that same cycle survives the wipe. After reset nothing is enabled, so the host has to write the enable register before the output can ever rise.

Top module: `irq_collect`

## Requirements
- R1: After reset the status register reads 0, the enable register reads 0 and `irq` is low.
- R2: A pulse on `evt[i]` sets status bit i at the next clock edge, and the bit stays set after the pulse ends, until a status read.
- R3: `irq` is high exactly when some status bit is set whose enable bit is 1 (a 1 in the enable register enables that source).
- R4: An event on a source whose enable bit is 0 still sets its status bit, and `irq` stays low.
- R5: A read with `sel`=0 returns the status register on `rdata` in the same cycle, and all status bits that had been recorded are cleared at the next edge.
- R6: An event that arrives in the same cycle as a status read is set in the status register after that edge.
- R7: A write with `sel`=1 loads `wdata` into the enable register at the next edge. A read with `sel`=1 returns it and leaves the status register unchanged.
- R8: A write with `sel`=0 leaves both the status register and the enable register unchanged.
- R9: Enabling a source whose status bit is already set raises `irq` in the cycle after the enable write, with no new event needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| evt | input | 16 | One-cycle event pulses, one per source |
| sel | input | 1 | Register select: 0 status, 1 enable |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the selected register |
| irq | output | 1 | Interrupt output, level high |

## Verification
The bench aims at a status read that coincides with a fresh event: a design that clears after merging would lose that event, and one that merges late would report it twice. It also polls sources while they are disabled. A design that gated the recording with the enable bits would read back zero there, and one that left the output ungated would raise `irq`. Writes to the status address and reads of the enable register are mixed in to catch decoding that clears or corrupts the wrong register. Late enabling of a pending bit catches an output that only reacts to new pulses.

// File: rtl/irq_collect.sv
module irq_collect #(
  parameter int N_SRC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt,
  input  logic             sel,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [N_SRC-1:0] wdata,
  output logic [N_SRC-1:0] rdata,
  output logic             irq
);
  localparam logic SEL_STATUS = 1'b0;
  localparam logic SEL_MASK   = 1'b1;

  logic [N_SRC-1:0] status_q;
  logic [N_SRC-1:0] mask_q;
  logic             stat_rd;
  logic             mask_wr;

  assign stat_rd = rd_en && (sel == SEL_STATUS);
  assign mask_wr = wr_en && (sel == SEL_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
    end else if (stat_rd) begin
      status_q <= evt;
    end else begin
      status_q <= status_q | evt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_wr) begin
      mask_q <= wdata;
    end
  end

  assign rdata = (sel == SEL_MASK) ? mask_q : status_q;
  assign irq   = |(status_q & mask_q);
endmodule

module irq_collect_chk #(
  parameter int N_SRC = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] evt,
  input logic             sel,
  input logic             rd_en,
  input logic             wr_en,
  input logic [N_SRC-1:0] wdata,
  input logic [N_SRC-1:0] status,
  input logic [N_SRC-1:0] mask,
  input logic             irq
);
  // R2: recorded bits survive any cycle without a status read
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && !sel) |=> ((status & $past(status)) == $past(status)));

  // R5, R6: after a status read only the same-cycle events remain
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !sel) |=> (status == $past(evt)));

  // R7: enable write loads wdata
  a_r7_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel) |=> (mask == $past(wdata)));

  // R8: write to status address touches neither register
  a_r8_status_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sel && !rd_en && (evt == '0)) |=> ($stable(status) && $stable(mask)));

  // R4: nothing enabled means the output is low
  a_r4_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);

  // R3: a high output needs an enabled pending bit
  a_r3_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((status & mask) != '0));
endmodule

bind irq_collect irq_collect_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt(evt), .sel(sel), .rd_en(rd_en),
  .wr_en(wr_en), .wdata(wdata), .status(status_q), .mask(mask_q), .irq(irq)
);

// File: tb/irq_collect_test.sv
module irq_collect_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt = '0;
  logic        sel = 1'b0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [15:0] m_status = '0;
  logic [15:0] m_mask   = '0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  irq_collect uut (
    .clk(clk), .rst_n(rst_n), .evt(evt), .sel(sel), .rd_en(rd_en),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // monitor: pops expected read data
  always @(negedge clk) begin
    if (rst_n && rd_en) begin
      logic [15:0] e;
      string t;
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard: read with no expected item, rdata=%h", rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          n_fail++;
          $display("FAIL %s: rdata actual=%h expected=%h", t, rdata, e);
        end
      end
    end
  end

  task automatic step(input logic [15:0] ev, input logic rd, input logic wr,
                      input logic s, input logic [15:0] wd, input string tag);
    @(posedge clk);
    #2;
    evt = ev; rd_en = rd; wr_en = wr; sel = s; wdata = wd;
    if (rd) begin
      exp_q.push_back(s ? m_mask : m_status);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    n_tests++;
    if (irq !== |(m_status & m_mask)) begin
      n_fail++;
      $display("FAIL %s: irq actual=%b expected=%b", tag, irq, |(m_status & m_mask));
    end
    if (wr && s) m_mask = wd;
    if (rd && !s) m_status = ev;
    else          m_status = m_status | ev;
  endtask

  task automatic idle(input string tag);
    step('0, 1'b0, 1'b0, 1'b0, '0, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1: reset state
    step('0, 1'b1, 1'b0, 1'b0, '0, "R1 status");
    step('0, 1'b1, 1'b0, 1'b1, '0, "R1 mask");
    // R4: masked events latched, irq low
    step(16'h0005, 1'b0, 1'b0, 1'b0, '0, "R4 evt");
    step(16'h8000, 1'b0, 1'b0, 1'b0, '0, "R2 evt");
    idle("R4 quiet");
    idle("R2 sticky");
    // R5: read returns and clears
    step('0, 1'b1, 1'b0, 1'b0, '0, "R5 read");
    step('0, 1'b1, 1'b0, 1'b0, '0, "R5 cleared");
    // R7: mask write and read
    step('0, 1'b0, 1'b1, 1'b1, 16'h00F0, "R7 write");
    step('0, 1'b1, 1'b0, 1'b1, '0, "R7 readback");
    // R3: enabled source raises irq, disabled one does not
    step(16'h0100, 1'b0, 1'b0, 1'b0, '0, "R3 off-mask evt");
    idle("R3 low");
    step(16'h0020, 1'b0, 1'b0, 1'b0, '0, "R3 on-mask evt");
    idle("R3 high");
    // R7: mask read leaves status alone
    step('0, 1'b1, 1'b0, 1'b1, '0, "R7 mask read");
    step('0, 1'b1, 1'b0, 1'b0, '0, "R7 status intact");
    idle("R3 low after clear");
    // R6: event coincident with read
    step(16'h0001, 1'b0, 1'b0, 1'b0, '0, "R6 pre");
    step(16'h0040, 1'b1, 1'b0, 1'b0, '0, "R6 read");
    idle("R6 kept irq");
    step('0, 1'b1, 1'b0, 1'b0, '0, "R6 kept value");
    // R8: write to status address ignored
    step(16'h0300, 1'b0, 1'b0, 1'b0, '0, "R8 pre");
    step('0, 1'b0, 1'b1, 1'b0, 16'hFFFF, "R8 write");
    step('0, 1'b1, 1'b0, 1'b0, '0, "R8 status");
    step('0, 1'b1, 1'b0, 1'b1, '0, "R8 mask");
    // R9: enabling a pending bit raises irq
    step(16'h0800, 1'b0, 1'b0, 1'b0, '0, "R9 pend");
    idle("R9 low");
    step('0, 1'b0, 1'b1, 1'b1, 16'h0800, "R9 enable");
    idle("R9 high");
    step('0, 1'b1, 1'b0, 1'b0, '0, "R9 read");
    idle("R9 low again");
    // R2: a held source stays recorded; all-ones pattern
    step(16'hFFFF, 1'b0, 1'b0, 1'b0, '0, "R2 all");
    step(16'hFFFF, 1'b0, 1'b0, 1'b0, '0, "R2 held");
    step('0, 1'b0, 1'b1, 1'b1, 16'hA5A5, "R3 pattern mask");
    idle("R3 pattern");
    step('0, 1'b1, 1'b0, 1'b0, '0, "R2 all read");
    idle("R5 empty");
    step('0, 1'b1, 1'b0, 1'b0, '0, "R5 empty read");
    idle("end");
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule